// File: doc/BRIEF.md
# DMA Completion Interrupt Mask Controller

This block collects end-of-block completion pulses from a set of DMA channels (32 by default) and drives one interrupt line per channel toward the processor. Each channel keeps a sticky completion flag and an interrupt-enable bit in its own status word. A single shared mask word gates every channel's interrupt, one bit per channel.

Software reaches the block through a plain register-bus slave port. It has an address, a write strobe, write data, and combinational read data. The mask can be loaded whole at the mask address. A set alias and a clear alias change single bits without a read-modify-write. A channel's flag is cleared by reading its status word and writing the same value back. A 1 in the flag position clears the flag, and the enable bit is written with the value it already holds.

Address map (word addresses, `ADDR_W = log2(NUM_CH)+1` bits): 0 is the mask, 1 the mask-set alias, 2 the mask-clear alias. Addresses with the top address bit set select a channel status word, with the channel index in the low bits. In a status word, bit 0 is the completion flag and bit 1 is the interrupt enable.

Top module: `dma_irq_mask_ctrl`

## Requirements
- R1: After reset, the mask reads 0, every status word reads 0, and every interrupt output is 0.
- R2: A write to address 0 loads the whole mask from the write data (bit n for channel n). Writing 0 masks every channel.
- R3: A write to address 1 sets every mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R4: A write to address 2 clears every mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R5: Reading address 0, 1 or 2 returns the current mask value.
- R6: A one-cycle high on `done_pulse[n]` sets the flag (status bit 0) of channel n on the next clock edge. The flag stays set until it is cleared.
- R7: A status write with bit 0 = 1 clears that channel's flag, and a write with bit 0 = 0 leaves the flag unchanged. Every status write loads bit 1 into the enable. Other channels are unaffected.
- R8: When a completion pulse and a clearing write reach the same channel in the same cycle, the flag stays set.
- R9: `irq_out[n]` is 1 exactly when channel n's flag, mask bit n and enable bit are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| done_pulse | input | NUM_CH | Per-channel end-of-block pulses |
| irq_out | output | NUM_CH | Per-channel interrupt lines |

## Verification
The hardest case to reach is a completion pulse landing in the same cycle as the write-back that clears the same flag. Software normally clears long after the event, so this race does not arise on its own. The bench places the pulse and the status write on the same falling edge, so both are seen at one rising edge. It then reads the flag back and checks the interrupt line. Each channel also goes through all eight flag, mask and enable combinations, so a miswired gate on any single channel shows up.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // Operation applied to the shared mask word in a given cycle.
  typedef enum logic [1:0] {
    MOP_NONE = 2'd0,
    MOP_LOAD = 2'd1,
    MOP_SET  = 2'd2,
    MOP_CLR  = 2'd3
  } mask_op_e;

  // Global word offsets (top address bit clear).
  localparam int OFF_MASK = 0;
  localparam int OFF_SET  = 1;
  localparam int OFF_CLR  = 2;

  // Status word field positions.
  localparam int ST_FLAG_BIT = 0;
  localparam int ST_EN_BIT   = 1;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mask_op_e          op,
  input  logic [NUM_CH-1:0] wword,
  output logic [NUM_CH-1:0] mask_q
);
  function automatic logic [NUM_CH-1:0] next_mask(
    input logic [NUM_CH-1:0] cur,
    input mask_op_e          o,
    input logic [NUM_CH-1:0] w
  );
    case (o)
      MOP_LOAD: return w;
      MOP_SET:  return cur | w;
      MOP_CLR:  return cur & ~w;
      default:  return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= next_mask(mask_q, op, wword);
  end

  // R2: a whole-word load appears in full one edge later.
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_LOAD) |=> (mask_q == $past(wword)));

  // R3: the set alias turns on the selected bits and leaves the rest alone.
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_SET) |=> (((mask_q & $past(wword)) == $past(wword)) &&
                         ((mask_q & ~$past(wword)) == ($past(mask_q) & ~$past(wword)))));

  // R4: the clear alias turns off the selected bits and leaves the rest alone.
  a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_CLR) |=> (((mask_q & $past(wword)) == '0) &&
                         ((mask_q & ~$past(wword)) == ($past(mask_q) & ~$past(wword)))));
endmodule

// File: rtl/irq_chan_flag.sv
module irq_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr,
  input  logic wr_flag,
  input  logic wr_en,
  output logic flag_q,
  output logic en_q
);
  logic clr_hit;
  assign clr_hit = wr & wr_flag;

  // A new event always wins over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      flag_q <= evt | (flag_q & ~clr_hit);
      if (wr) en_q <= wr_en;
    end
  end

  // R6: a pulse sets the flag.
  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  // R6: the flag is sticky without a clear.
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_hit) |=> flag_q);
  // R7: a clear without an event drops the flag.
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !evt) |=> !flag_q);
  // R8: event and clear together keep the flag.
  a_r8_race_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && evt) |=> flag_q);
endmodule

// File: rtl/dma_irq_mask_ctrl.sv
module dma_irq_mask_ctrl
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32,
  parameter int CH_W   = (NUM_CH > 4) ? $clog2(NUM_CH) : 2,
  parameter int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] done_pulse,
  output logic [NUM_CH-1:0] irq_out
);
  logic              is_chan;
  logic [CH_W-1:0]   low_idx;
  logic              chan_ok;
  mask_op_e          mop;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] en_q;

  assign is_chan = bus_addr[ADDR_W-1];
  assign low_idx = bus_addr[CH_W-1:0];
  assign chan_ok = is_chan && (int'(low_idx) < NUM_CH);

  always_comb begin
    mop = MOP_NONE;
    if (bus_we && !is_chan) begin
      case (int'(low_idx))
        OFF_MASK: mop = MOP_LOAD;
        OFF_SET:  mop = MOP_SET;
        OFF_CLR:  mop = MOP_CLR;
        default:  mop = MOP_NONE;
      endcase
    end
  end

  irq_mask_bank #(.NUM_CH(NUM_CH)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (mop),
    .wword  (bus_wdata[NUM_CH-1:0]),
    .mask_q (mask_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_sel;
    assign wr_sel = bus_we && is_chan && (low_idx == CH_W'(g));
    irq_chan_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (done_pulse[g]),
      .wr      (wr_sel),
      .wr_flag (bus_wdata[ST_FLAG_BIT]),
      .wr_en   (bus_wdata[ST_EN_BIT]),
      .flag_q  (flag_q[g]),
      .en_q    (en_q[g])
    );
  end

  assign irq_out = flag_q & mask_q & en_q;

  always_comb begin
    bus_rdata = '0;
    if (chan_ok) begin
      bus_rdata[ST_FLAG_BIT] = flag_q[low_idx];
      bus_rdata[ST_EN_BIT]   = en_q[low_idx];
    end else if (!is_chan && (int'(low_idx) <= OFF_CLR)) begin
      bus_rdata[NUM_CH-1:0] = mask_q;
    end
  end

  // R9: an unmasked-off line cannot be raised by the mask alone.
  a_r9_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) == '0 && done_pulse == '0 && $stable(flag_q)) |-> (irq_out == '0));
endmodule

// File: tb/test_dma_irq_mask_ctrl.sv
module test_dma_irq_mask_ctrl;
  localparam int N  = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  done_pulse = '0;
  logic [N-1:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] m_mask = '0, m_flag = '0, m_en = '0;

  always #2 clk = ~clk;

  dma_irq_mask_ctrl i_dma_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_pulse(done_pulse), .irq_out(irq_out)
  );

  function automatic logic [AW-1:0] ch_addr(input int n);
    return {1'b1, 5'(n)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    done_pulse[n] = 1'b1;
    @(negedge clk);
    done_pulse[n] = 1'b0;
  endtask

  task automatic check_irq(input string req);
    #1 check(req, 32'(irq_out), 32'(m_flag & m_mask & m_en));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(6'd0, d); check("R1 mask", d, 0);
    for (int n = 0; n < N; n++) begin rd(ch_addr(n), d); check("R1 status", d, 0); end
    check_irq("R1 irq");

    // R2: whole-word load, then all-masked
    wr(6'd0, 32'hA5A5_3C3C); rd(6'd0, d); check("R2 load", d, 32'hA5A5_3C3C);
    wr(6'd0, 32'h0); rd(6'd0, d); check("R2 zero", d, 0);

    // R3 / R5: walk set alias upward
    for (int n = 0; n < N; n++) begin
      wr(6'd1, 32'(1) << n); m_mask[n] = 1'b1;
      rd(6'd1, d); check("R3 set walk (R5 via set addr)", d, m_mask);
    end
    // R4 / R5: walk clear alias downward
    for (int n = N - 1; n >= 0; n--) begin
      wr(6'd2, 32'(1) << n); m_mask[n] = 1'b0;
      rd(6'd2, d); check("R4 clr walk (R5 via clr addr)", d, m_mask);
    end
    wr(6'd1, 32'hF0F0_1234); m_mask |= 32'hF0F0_1234;
    wr(6'd2, 32'h3030_0204); m_mask &= ~32'h3030_0204;
    rd(6'd0, d); check("R4 multi-bit mix", d, m_mask);
    rd(6'd1, d); check("R5 set addr read", d, m_mask);
    rd(6'd2, d); check("R5 clr addr read", d, m_mask);
    wr(6'd0, 32'h0); m_mask = '0;

    // Per channel: flag, clear, race and eight gating combinations
    for (int n = 0; n < N; n++) begin
      pulse(n); m_flag[n] = 1'b1;
      rd(ch_addr(n), d); check("R6 flag set", d, 32'h1);
      rd(ch_addr((n + 1) % N), d); check("R7 other channel untouched", d, 0);
      repeat (3) @(negedge clk);
      rd(ch_addr(n), d); check("R6 sticky", d, 32'h1);
      wr(ch_addr(n), 32'h2); m_en[n] = 1'b1;
      rd(ch_addr(n), d); check("R7 bit0=0 keeps flag, loads enable", d, 32'h3);
      wr(ch_addr(n), d); m_flag[n] = 1'b0;
      rd(ch_addr(n), d); check("R7 write-back clears", d, 32'h2);
      // R8: pulse and clearing write on the same edge
      @(negedge clk);
      bus_addr = ch_addr(n); bus_we = 1'b1; bus_wdata = 32'h3; done_pulse[n] = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; done_pulse[n] = 1'b0; m_flag[n] = 1'b1;
      rd(ch_addr(n), d); check("R8 race keeps flag", d, 32'h3);
      for (int c = 0; c < 8; c++) begin
        wr(6'd0, c[0] ? (32'(1) << n) : 32'h0); m_mask = c[0] ? (N'(1) << n) : '0;
        wr(ch_addr(n), {30'd0, c[1], 1'b1}); m_en[n] = c[1]; m_flag[n] = 1'b0;
        if (c[2]) begin pulse(n); m_flag[n] = 1'b1; end
        check_irq("R9 gating");
      end
      wr(ch_addr(n), 32'h1); m_flag[n] = 1'b0; m_en[n] = 1'b0;
      wr(6'd0, 32'h0); m_mask = '0;
      check_irq("R9 quiet after cleanup");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule